// File: doc/BRIEF.md
# Nibble-Bus Synchronous Serial Port

This block is a half-duplex, three-wire synchronous serial port for a controller with a 4-bit data bus. An 8-bit shift register sends one bit per shift clock on the serial output. On the same shift clock it captures one bit from the serial input. Software loads the byte to send as two nibbles, starts the transfer, and reads the received byte back as two nibbles once the completion interrupt rises.

In master mode the port generates the serial clock itself. It uses one of three prescaler tick strobes, each accepted tick toggles the clock pin, and the port drives an active-low chip-select for the whole transfer. In slave mode the serial clock arrives on an input pin. That pin and the serial data input are brought into the system clock domain through a two-stage synchronizer, and the shared select pin then reports that a byte is loaded and waiting. In both modes, software chooses the active clock edge and the bit order.

Register map on the 3-bit address:

| Address | Write | Read |
|---|---|---|
| 0 | low transmit nibble | low nibble of the shift register |
| 1 | high transmit nibble | high nibble of the shift register |
| 2 | configuration: bit 0 master, bit 1 falling active edge, bit 2 MSB first, bit 3 enable | configuration |
| 3 | command: bits 1:0 tick select, bit 2 start, bit 3 abort | tick select in bits 1:0 |
| 4 | (none) | status: bit 0 busy, bit 1 interrupt flag, bit 2 byte loaded; a read with `bus_re` clears the flag |

Top module: `nsp_top`

## Requirements
- R1: While idle, a write to address 0 or 1 loads bits 3:0 or 7:4 of the shift register. Reads of addresses 0 and 1 return the same two nibbles of the shift register in the cycle the address is presented.
- R2: A write to address 3 with bit 2 set and bit 3 clear starts a transfer only while idle and with configuration bit 3 (enable) set. Status bit 0 (busy) reads 1 from the next cycle on. With enable clear the start has no effect.
- R3: In master mode, each cycle in which the selected tick strobe is high toggles `sclk_out` at that clock edge. Command bits 1:0 value 0, 1 or 2 select `tap_tick[0]`, `[1]` or `[2]`, and value 3 selects `tap_tick[2]`. Strobes on unselected taps leave `sclk_out` unchanged.
- R4: The master clock rests high when configuration bit 1 is 0 (rising active edge) and low when it is 1 (falling). Every second toggle of a transfer is an active edge, and a byte takes 16 toggles, which leaves the clock back at its resting level.
- R5: `sout` presents bit 7 of the shift register when configuration bit 2 is 1 and bit 0 when it is 0, so the loaded byte leaves in the selected order. The next bit appears after each active edge.
- R6: On each active edge the shift register takes in the synchronized serial input at the end opposite `sout`. After a byte, the register holds the received byte with the first bit received in bit 7 (MSB first) or in bit 0 (LSB first).
- R7: At the clock edge that processes the eighth active edge, busy clears and `irq` rises together.
- R8: `irq` (status bit 1) stays set until address 4 is read with `bus_re` high, and clears at that clock edge.
- R9: In slave mode `sclk_oe` is 0, and the active edge of `sclk_in` (rising for configuration bit 1 = 0, falling for 1) acts at the third clock edge after the pin changes.
- R10: `sel_out` is chip-select in master mode: low while busy and high while idle. In slave mode it is the ready flag: high while a byte is loaded (status bit 2, set by a nibble write, cleared at completion) and no transfer is in progress.
- R11: While busy, writes to addresses 0, 1 and 2 are ignored and do not alter the byte being sent or the mode.
- R12: A write to address 3 with bit 3 set aborts at once. Busy, the interrupt flag, the loaded flag and the shift register are cleared, the master clock returns to rest, and the configuration is kept.
- R13: After reset, status, data and configuration read 0, all output enables are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | register write strobe |
| bus_re | input | 1 | register read strobe (clears the interrupt flag on a status read) |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 4 | write data nibble |
| bus_rdata | output | 4 | read data nibble for the presented address |
| tap_tick | input | 3 | prescaler tick strobes, one per tap |
| sin_pin | input | 1 | serial data input |
| sclk_in | input | 1 | external serial clock (slave mode) |
| sclk_out | output | 1 | generated serial clock (master mode) |
| sclk_oe | output | 1 | output enable for the clock pin |
| sout | output | 1 | serial data output |
| sout_oe | output | 1 | output enable for the data output pin |
| sel_out | output | 1 | chip-select (master) or ready (slave) |
| sel_oe | output | 1 | output enable for the select pin |
| irq | output | 1 | transfer-complete interrupt |

## Verification
In master mode every result is due one edge after its cause. A tick strobe changes `sclk_out`, a command write changes busy, and the last tick raises `irq` and drops busy. The bench therefore drives each stimulus for one cycle and samples just after the next edge. It also checks busy on both sides of the final tick. Slave-mode results lag the pin by the synchronizer: the bench checks busy still set two edges after the last active pin edge and clear at the third. It holds each `sin_pin` bit for four cycles before the edge, so that the bit passes the synchronizer before it is sampled, and reads `sout` only after the previous edge has settled.

// File: rtl/nsp_pkg.sv
package nsp_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_W    = 3;
  localparam int TAP_SEL_W = 2;

  localparam logic [ADDR_W-1:0] A_DLO  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DHI  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int CMD_START = 2;
  localparam int CMD_ABORT = 3;

  // configuration nibble: bit3 enable, bit2 msb first, bit1 falling edge, bit0 master
  typedef struct packed {
    logic en;
    logic msb;
    logic fall;
    logic master;
  } cfg_t;
endpackage

// File: rtl/nsp_regs.sv
module nsp_regs
  import nsp_pkg::*;
#(
  parameter int DATA_W = 2 * NIB_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [NIB_W-1:0]     bus_wdata,
  output logic [NIB_W-1:0]     bus_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [DATA_W-1:0]    shreg,
  output cfg_t                 cfg,
  output logic [TAP_SEL_W-1:0] tap_sel,
  output logic                 start,
  output logic                 abort,
  output logic                 ld_lo,
  output logic                 ld_hi,
  output logic                 irq,
  output logic                 loaded
);
  cfg_t                 cfg_q, cfg_d;
  logic [TAP_SEL_W-1:0] tap_q, tap_d;
  logic                 irq_q, irq_d;
  logic                 ld_q, ld_d;
  logic                 wr_cfg, wr_cmd, rd_stat;

  always_comb begin
    wr_cfg  = bus_we && (bus_addr == A_CFG) && !busy;
    wr_cmd  = bus_we && (bus_addr == A_CMD);
    rd_stat = bus_re && (bus_addr == A_STAT);
    abort   = wr_cmd && bus_wdata[CMD_ABORT];
    start   = wr_cmd && bus_wdata[CMD_START] && !bus_wdata[CMD_ABORT]
              && cfg_q.en && !busy;
    ld_lo   = bus_we && (bus_addr == A_DLO) && !busy;
    ld_hi   = bus_we && (bus_addr == A_DHI) && !busy;
  end

  always_comb begin
    cfg_d = cfg_q;
    tap_d = tap_q;
    if (wr_cfg) cfg_d = cfg_t'(bus_wdata);
    if (wr_cmd && !busy && !bus_wdata[CMD_ABORT]) tap_d = bus_wdata[TAP_SEL_W-1:0];

    irq_d = irq_q;
    if (rd_stat) irq_d = 1'b0;
    if (done)    irq_d = 1'b1;
    if (abort)   irq_d = 1'b0;

    ld_d = ld_q;
    if (ld_lo || ld_hi) ld_d = 1'b1;
    if (done || abort)  ld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tap_q <= '0;
      irq_q <= 1'b0;
      ld_q  <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      tap_q <= tap_d;
      irq_q <= irq_d;
      ld_q  <= ld_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_DLO:   bus_rdata = shreg[NIB_W-1:0];
      A_DHI:   bus_rdata = shreg[DATA_W-1:NIB_W];
      A_CFG:   bus_rdata = cfg_q;
      A_CMD:   bus_rdata = NIB_W'(tap_q);
      A_STAT:  bus_rdata = {1'b0, ld_q, irq_q, busy};
      default: bus_rdata = '0;
    endcase
  end

  assign cfg     = cfg_q;
  assign tap_sel = tap_q;
  assign irq     = irq_q;
  assign loaded  = ld_q;

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !abort) |=> irq_q);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !rd_stat && !abort) |=> irq_q);
endmodule

// File: rtl/nsp_clkgen.sv
module nsp_clkgen
  import nsp_pkg::*;
#(
  parameter int N_TAPS      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 abort,
  input  logic                 busy,
  input  logic                 master,
  input  logic                 fall,
  input  logic [TAP_SEL_W-1:0] tap_sel,
  input  logic [N_TAPS-1:0]    tap_tick,
  input  logic                 sclk_in,
  input  logic                 sin_pin,
  output logic                 act,
  output logic                 sin_s,
  output logic                 sclk_out
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclk_sync, sin_sync;
  logic                   sclk_prev;
  logic                   sclk_q, sclk_d, ph_q, ph_d;
  logic [TAP_SEL_W-1:0]   tap_idx;
  logic                   tick_sel, idle_lvl;
  logic                   s_rise, s_fall, m_act, s_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      sin_sync  <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk_in};
      sin_sync  <= {sin_sync[SYNC_STAGES-2:0], sin_pin};
      sclk_prev <= sclk_sync[LAST];
    end
  end

  always_comb begin
    tap_idx = (int'(tap_sel) >= N_TAPS) ? TAP_SEL_W'(N_TAPS - 1) : tap_sel;
    tick_sel = 1'b0;
    for (int i = 0; i < N_TAPS; i++)
      if (tap_idx == TAP_SEL_W'(i)) tick_sel = tap_tick[i];
  end

  always_comb begin
    idle_lvl = !fall;
    sclk_d   = sclk_q;
    ph_d     = ph_q;
    if (abort || !busy || !master) begin
      sclk_d = idle_lvl;
      ph_d   = 1'b0;
    end else if (tick_sel) begin
      sclk_d = !sclk_q;
      ph_d   = !ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      ph_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      ph_q   <= ph_d;
    end
  end

  always_comb begin
    s_rise = sclk_sync[LAST] && !sclk_prev;
    s_fall = !sclk_sync[LAST] && sclk_prev;
    m_act  = master && busy && tick_sel && ph_q;
    s_act  = !master && busy && (fall ? s_fall : s_rise);
    act    = m_act || s_act;
  end

  assign sin_s    = sin_sync[LAST];
  assign sclk_out = sclk_q;

  // R3
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && master && !tick_sel && !abort) |=> $stable(sclk_out));

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && !busy) |=> (sclk_out == $past(idle_lvl)));
endmodule

// File: rtl/nsp_shifter.sv
module nsp_shifter
  import nsp_pkg::*;
#(
  parameter int DATA_W = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              act,
  input  logic              sin_s,
  input  logic              msb,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [NIB_W-1:0]  wdata,
  output logic [DATA_W-1:0] shreg,
  output logic              busy,
  output logic              done,
  output logic              sout
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              shift_en;

  always_comb begin
    shift_en = act && busy_q;
    done     = shift_en && (cnt_q == CNT_W'(DATA_W - 1)) && !abort;
  end

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (abort) begin
      sh_d   = '0;
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (start) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (shift_en) begin
      sh_d   = msb ? {sh_q[DATA_W-2:0], sin_s} : {sin_s, sh_q[DATA_W-1:1]};
      cnt_d  = cnt_q + CNT_W'(1);
      if (done) busy_d = 1'b0;
    end else begin
      if (ld_lo) sh_d[NIB_W-1:0]      = wdata;
      if (ld_hi) sh_d[DATA_W-1:NIB_W] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign shreg = sh_q;
  assign busy  = busy_q;
  assign sout  = msb ? sh_q[DATA_W-1] : sh_q[0];

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(done || abort));

  // R11
  shreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !act && !abort) |=> $stable(sh_q));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/nsp_top.sv
module nsp_top
  import nsp_pkg::*;
#(
  parameter int N_TAPS      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 2 * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_wdata,
  output logic [NIB_W-1:0]  bus_rdata,
  input  logic [N_TAPS-1:0] tap_tick,
  input  logic              sin_pin,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sout,
  output logic              sout_oe,
  output logic              sel_out,
  output logic              sel_oe,
  output logic              irq
);
  logic [1:0]           rst_pipe;
  logic                 rst_i_n;
  cfg_t                 cfg;
  logic [TAP_SEL_W-1:0] tap_sel;
  logic                 start, abort, ld_lo, ld_hi, loaded;
  logic                 busy, done, act, sin_s;
  logic [DATA_W-1:0]    shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  nsp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .shreg(shreg), .cfg(cfg), .tap_sel(tap_sel),
    .start(start), .abort(abort), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .irq(irq), .loaded(loaded)
  );

  nsp_clkgen #(.N_TAPS(N_TAPS), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk(clk), .rst_n(rst_i_n), .abort(abort), .busy(busy),
    .master(cfg.master), .fall(cfg.fall), .tap_sel(tap_sel),
    .tap_tick(tap_tick), .sclk_in(sclk_in), .sin_pin(sin_pin),
    .act(act), .sin_s(sin_s), .sclk_out(sclk_out)
  );

  nsp_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk(clk), .rst_n(rst_i_n), .abort(abort), .start(start), .act(act),
    .sin_s(sin_s), .msb(cfg.msb), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .wdata(bus_wdata), .shreg(shreg), .busy(busy), .done(done), .sout(sout)
  );

  always_comb begin
    sclk_oe = cfg.en && cfg.master;
    sout_oe = cfg.en;
    sel_oe  = cfg.en;
    sel_out = cfg.master ? !busy : (loaded && !busy);
  end

  // R7
  start_done_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({start, done}));

  // R10
  cs_during_xfer_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(busy) && cfg.master) |-> !sel_out);
endmodule

// File: tb/nsp_top_tb.sv
module nsp_top_tb;
  logic       clk, rst_n, bus_we, bus_re, sin_pin, sclk_in;
  logic [2:0] bus_addr, tap_tick;
  logic [3:0] bus_wdata, bus_rdata;
  logic       sclk_out, sclk_oe, sout, sout_oe, sel_out, sel_oe, irq;
  int         n_chk, n_fail;
  logic       finished;

  nsp_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tap_tick(tap_tick), .sin_pin(sin_pin), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sout(sout), .sout_oe(sout_oe),
    .sel_out(sel_out), .sel_oe(sel_oe), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not end act=hung exp=done");
    report();
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    cyc(1);
    bus_we = 1'b0;
  endtask

  task automatic rdv(input logic [2:0] a, output logic [3:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [7:0] bit_of(input logic [7:0] b, input int k, input logic msb);
    return {7'd0, msb ? b[7-k] : b[k]};
  endfunction

  task automatic read_byte(output logic [7:0] v);
    logic [3:0] lo, hi;
    rdv(3'd0, lo);
    rdv(3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic clear_irq();
    logic [3:0] s;
    cyc(5);
    check("R8 irq held", {7'd0, irq}, 8'd1);
    bus_addr = 3'd4; bus_re = 1'b1;
    cyc(1);
    bus_re = 1'b0;
    rdv(3'd4, s);
    check("R8 irq cleared by status read", {6'd0, irq, s[1]}, 8'd0);
  endtask

  task automatic xfer_m(input logic [7:0] tx, input logic [7:0] rx, input logic msb,
                        input logic fall, input logic [1:0] tap, input logic inj);
    logic [7:0] obs, got;
    logic [3:0] s;
    logic       bad, idle;
    int         tsel;
    tsel = (tap == 2'd3) ? 2 : int'(tap);
    idle = !fall;
    bad  = 1'b0;
    obs  = '0;
    wr(3'd2, {1'b1, msb, fall, 1'b1});
    wr(3'd3, {2'b00, tap});
    wr(3'd0, tx[3:0]);
    wr(3'd1, tx[7:4]);
    check("R10 cs idle high", {7'd0, sel_out}, 8'd1);
    check("R4 resting clock", {7'd0, sclk_out}, {7'd0, idle});
    wr(3'd3, {2'b01, tap});
    rdv(3'd4, s);
    check("R2 busy after start", {7'd0, s[0]}, 8'd1);
    check("R10 cs low while busy", {7'd0, sel_out}, 8'd0);
    for (int t = 0; t < 16; t++) begin
      if (t % 2 == 1) begin
        int k;
        k = (t - 1) / 2;
        sin_pin = bit_of(rx, k, msb)[0];
        cyc(3);
        obs[msb ? 7 - k : k] = sout;
      end
      if (inj && t == 5) begin
        wr(3'd0, ~tx[3:0]);
        wr(3'd1, ~tx[7:4]);
        wr(3'd2, {1'b1, ~msb, fall, 1'b1});
      end
      tap_tick = 3'b111 & ~(3'b001 << tsel);
      cyc(1);
      tap_tick = 3'b000;
      if (sclk_out !== (idle ^ t[0])) bad = 1'b1;
      tap_tick = 3'b001 << tsel;
      cyc(1);
      tap_tick = 3'b000;
      if (sclk_out !== (idle ^ !t[0])) bad = 1'b1;
      if (t == 14) begin
        rdv(3'd4, s);
        check("R7 busy before last edge", {6'd0, s[1:0]}, 8'd1);
      end
      if (t == 15) begin
        rdv(3'd4, s);
        check("R7 done at eighth active edge", {6'd0, s[1:0]}, 8'd2);
        check("R7 irq pin", {7'd0, irq}, 8'd1);
      end
    end
    check("R3 R4 master clock toggles", {7'd0, bad}, 8'd0);
    check(inj ? "R11 R5 sent byte unaffected" : "R5 sent byte", obs, tx);
    read_byte(got);
    check(inj ? "R11 R6 received byte" : "R6 R1 received byte", got, rx);
    check("R4 clock back at rest", {7'd0, sclk_out}, {7'd0, idle});
    check("R10 cs released", {7'd0, sel_out}, 8'd1);
    if (inj) begin
      rdv(3'd2, s);
      check("R11 config write ignored", {4'd0, s}, {4'd0, 1'b1, msb, fall, 1'b1});
    end
    clear_irq();
  endtask

  task automatic xfer_s(input logic [7:0] tx, input logic [7:0] rx, input logic msb,
                        input logic fall);
    logic [7:0] obs, got;
    logic [3:0] s;
    logic       idle;
    idle    = fall;
    sclk_in = idle;
    obs     = '0;
    wr(3'd2, {1'b1, msb, fall, 1'b0});
    cyc(4);
    wr(3'd0, tx[3:0]);
    wr(3'd1, tx[7:4]);
    check("R9 clock pin not driven", {7'd0, sclk_oe}, 8'd0);
    check("R10 ready after load", {7'd0, sel_out}, 8'd1);
    wr(3'd3, 4'b0100);
    check("R10 ready low while busy", {7'd0, sel_out}, 8'd0);
    for (int k = 0; k < 8; k++) begin
      sin_pin = bit_of(rx, k, msb)[0];
      cyc(4);
      obs[msb ? 7 - k : k] = sout;
      sclk_in = !idle;
      if (k == 7) begin
        cyc(2);
        rdv(3'd4, s);
        check("R9 edge still in synchronizer", {7'd0, s[0]}, 8'd1);
        cyc(1);
        rdv(3'd4, s);
        check("R9 R7 done third edge after pin", {6'd0, s[1:0]}, 8'd2);
        cyc(1);
      end else begin
        cyc(4);
      end
      sclk_in = idle;
      cyc(4);
    end
    check("R5 slave sent byte", obs, tx);
    read_byte(got);
    check("R6 slave received byte", got, rx);
    check("R10 ready cleared after completion", {7'd0, sel_out}, 8'd0);
    clear_irq();
  endtask

  initial begin
    logic [3:0] v;
    logic [7:0] b;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0; bus_addr = '0; bus_wdata = '0;
    tap_tick = '0; sin_pin = 1'b0; sclk_in = 1'b0;
    void'($urandom(32'd4242));
    cyc(3);
    rst_n = 1'b1;
    cyc(4);

    rdv(3'd4, v); check("R13 status after reset", {4'd0, v}, 8'd0);
    read_byte(b); check("R13 data after reset", b, 8'd0);
    rdv(3'd2, v); check("R13 config after reset", {4'd0, v}, 8'd0);
    check("R13 enables and irq", {4'd0, sclk_oe, sout_oe, sel_oe, irq}, 8'd0);

    wr(3'd0, 4'h5); wr(3'd1, 4'hA);
    read_byte(b); check("R1 nibble load while idle", b, 8'hA5);
    wr(3'd3, 4'b0100);
    rdv(3'd4, v); check("R2 start ignored when disabled", {7'd0, v[0]}, 8'd0);

    xfer_m(8'hC3, 8'h5A, 1'b1, 1'b0, 2'd0, 1'b0);
    xfer_m(8'h81, 8'h3C, 1'b0, 1'b1, 2'd3, 1'b0);
    xfer_m(8'h6E, 8'hB1, 1'b1, 1'b1, 2'd1, 1'b1);
    xfer_s(8'h96, 8'h2D, 1'b1, 1'b0);
    xfer_s(8'h17, 8'hE8, 1'b0, 1'b1);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] tx, rx;
      logic [1:0] tap;
      logic       msb, fall, mst;
      tx = 8'($urandom); rx = 8'($urandom);
      tap = 2'($urandom); msb = 1'($urandom); fall = 1'($urandom); mst = 1'($urandom);
      if (mst) xfer_m(tx, rx, msb, fall, tap, 1'b0);
      else     xfer_s(tx, rx, msb, fall);
    end

    wr(3'd2, 4'b1011);
    wr(3'd0, 4'h7); wr(3'd1, 4'h3);
    wr(3'd3, 4'b0100);
    for (int t = 0; t < 3; t++) begin
      tap_tick = 3'b001; cyc(1); tap_tick = 3'b000; cyc(2);
    end
    wr(3'd3, 4'b1000);
    rdv(3'd4, v); check("R12 abort clears status", {4'd0, v}, 8'd0);
    read_byte(b); check("R12 abort clears shift register", b, 8'd0);
    check("R12 clock at rest after abort", {7'd0, sclk_out}, 8'd0);
    rdv(3'd2, v); check("R12 config kept", {4'd0, v}, 8'h0B);

    report();
  end
endmodule